// File: doc/BRIEF.md
# Four-Channel Buffered Pulse-Width Modulator

This block drives four independent pulse-width modulated lines from a simple 32-bit register bus. Each channel owns an up-counter. The counter advances on a prescaled tick, runs from zero to one below the programmed period, and then wraps. The channel output is in its asserted phase while the count is at or above the programmed duty value. The duty value therefore measures the part of each period that is not asserted. A polarity bit swaps the asserted and idle levels.

Software starts channels through a set-style command word and stops them through a clear-style command word. A stop request is honoured only at the next period end, so the last pulse is never cut short. On a running channel, duty changes go through a shadow register that is committed at the period boundary, and direct duty and period writes are refused. A flag register records one period-end event per channel. Reading it clears it, and a level interrupt output is high while any flag is set.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Writing to byte offset 0x004 starts channel n for every bit n that is one, and zero bits leave their channel unchanged. The word at offset 0x00C reads back one running bit per channel in bits [3:0], so all four running reads as 0x0F.
- R2: A running channel counts prescaled ticks from 0 to period-1 and then wraps to 0. With normal polarity its output is high while count >= duty and low otherwise, so it is high for period-duty ticks of each period.
- R3: Mode bits [3:0] hold a prescale select s, and the counter advances once every 2^s clocks counted from the start edge. A written value above 10 is stored and read back as 10.
- R4: Mode bit 9 inverts the output. A stopped channel drives the inactive level, which equals bit 9, and the mode word reads back bit 9 and bits [3:0].
- R5: Channel n occupies 0x200 + n*0x20, with the mode word at +0x00, duty at +0x04, duty update at +0x08 and period at +0x0C. Only the low 16 bits of duty, update and period are stored, and the upper 16 bits read as zero.
- R6: While a channel runs, a write to the duty-update word is held and becomes the active duty at the first period end strictly after the write edge. Writes to the duty or period words are ignored while the channel runs.
- R7: While a channel is stopped, writes to the duty, duty-update and period words take effect at once. A duty-update write sets both the active duty and the shadow.
- R8: Offset 0x01C holds one flag per channel, set at each period end of that channel. A read returns the flags and clears them, and a period end in the same cycle as the read stays set. Output irq is high while any flag is set.
- R9: Writing to offset 0x008 stops channel n for every bit n that is one. The stop takes effect at the first period end strictly after the write edge. The running bit stays set until then, after which the output is at the inactive level and the counter is zero.
- R10: After reset, every register reads zero, all channels are stopped and all outputs are low.
- R11: bus_rdata takes the addressed value on the clock edge that samples bus_rd and holds it until the next read. Unmapped offsets read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| pwm_out | output | 4 | One modulated line per channel |
| irq | output | 1 | High while any period-end flag is set |

## Verification
Several rules are checked on every cycle by the assertions. A channel starts only after a start command and stops only on a period-end edge. A period-end flag rises only on a period end. The active duty of a running channel changes only at a period boundary, and the count stays below a nonzero period. The exact waveform under different periods, duties, prescales and polarities can only be shown by the bench scenarios, which compare every output cycle against a model. The same holds for the first-boundary timing of shadowed duty commits and delayed stops, the refusal of direct writes on running channels, the prescale clamp and the read-to-clear behaviour.

// File: rtl/pwm_quad_ctrl.sv
module pwm_quad_ctrl #(
  parameter int AW = 12,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic [3:0]    pwm_out,
  output logic          irq
);
  localparam int NCH    = 4;
  localparam int CW     = 16;
  localparam int PW     = 4;
  localparam int MAXPRE = 10;
  localparam int DIVW   = MAXPRE;
  localparam int POLB   = 9;

  logic [PW-1:0]   pre_q  [NCH];
  logic [CW-1:0]   per_q  [NCH];
  logic [CW-1:0]   duty_q [NCH];
  logic [CW-1:0]   shd_q  [NCH];
  logic [CW-1:0]   cnt_q  [NCH];
  logic [DIVW-1:0] div_q  [NCH];
  logic [DIVW-1:0] mask   [NCH];
  logic [NCH-1:0]  run_q, stop_q, pend_q, pol_q, isr_q;
  logic [NCH-1:0]  tick, wrap, ge;
  logic [NCH-1:0]  wr_mode, wr_duty, wr_upd, wr_per;
  logic [DW-1:0]   rd_mux;
  logic            unused_hi;

  wire       glb_sel = (bus_addr[AW-1:5] == '0);
  wire       ch_sel  = (bus_addr[AW-1:9] == (AW-9)'(1)) && (bus_addr[8:7] == 2'b00)
                       && (bus_addr[1:0] == 2'b00);
  wire [1:0] ch_idx  = bus_addr[6:5];
  wire [2:0] ch_reg  = bus_addr[4:2];
  wire       wr_ena  = bus_wr && glb_sel && (bus_addr[4:0] == 5'h04);
  wire       wr_dis  = bus_wr && glb_sel && (bus_addr[4:0] == 5'h08);
  wire       rd_isr  = bus_rd && glb_sel && (bus_addr[4:0] == 5'h1C);
  wire [PW-1:0] pre_in = (bus_wdata[PW-1:0] > PW'(MAXPRE)) ? PW'(MAXPRE) : bus_wdata[PW-1:0];

  assign unused_hi = ^bus_wdata[DW-1:CW];

  always_comb begin
    for (int n = 0; n < NCH; n++) begin
      mask[n]    = DIVW'((11'd1 << pre_q[n]) - 11'd1);
      tick[n]    = div_q[n] >= mask[n];
      wrap[n]    = run_q[n] && tick[n] && (({1'b0, cnt_q[n]} + 17'd1) >= {1'b0, per_q[n]});
      ge[n]      = cnt_q[n] >= duty_q[n];
      pwm_out[n] = (run_q[n] & ge[n]) ^ pol_q[n];
      wr_mode[n] = bus_wr && ch_sel && (ch_idx == 2'(n)) && (ch_reg == 3'd0);
      wr_duty[n] = bus_wr && ch_sel && (ch_idx == 2'(n)) && (ch_reg == 3'd1);
      wr_upd[n]  = bus_wr && ch_sel && (ch_idx == 2'(n)) && (ch_reg == 3'd2);
      wr_per[n]  = bus_wr && ch_sel && (ch_idx == 2'(n)) && (ch_reg == 3'd3);
    end
  end

  assign irq = |isr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= '0;
      stop_q <= '0;
      pend_q <= '0;
      pol_q  <= '0;
      isr_q  <= '0;
      for (int n = 0; n < NCH; n++) begin
        pre_q[n]  <= '0;
        per_q[n]  <= '0;
        duty_q[n] <= '0;
        shd_q[n]  <= '0;
        cnt_q[n]  <= '0;
        div_q[n]  <= '0;
      end
    end else begin
      isr_q <= (rd_isr ? '0 : isr_q) | wrap;
      for (int n = 0; n < NCH; n++) begin
        if (wr_mode[n]) begin
          pol_q[n] <= bus_wdata[POLB];
          pre_q[n] <= pre_in;
        end
        if (!run_q[n]) begin
          cnt_q[n]  <= '0;
          div_q[n]  <= '0;
          stop_q[n] <= 1'b0;
          pend_q[n] <= 1'b0;
          if (wr_ena && bus_wdata[n]) run_q[n] <= 1'b1;
          if (wr_duty[n]) duty_q[n] <= bus_wdata[CW-1:0];
          if (wr_per[n])  per_q[n]  <= bus_wdata[CW-1:0];
          if (wr_upd[n]) begin
            duty_q[n] <= bus_wdata[CW-1:0];
            shd_q[n]  <= bus_wdata[CW-1:0];
          end
        end else begin
          div_q[n] <= tick[n] ? '0 : div_q[n] + 1'b1;
          if (tick[n]) cnt_q[n] <= wrap[n] ? '0 : cnt_q[n] + 1'b1;
          if (wr_ena && bus_wdata[n])      stop_q[n] <= 1'b0;
          else if (wr_dis && bus_wdata[n]) stop_q[n] <= 1'b1;
          if (wrap[n]) begin
            if (pend_q[n]) duty_q[n] <= shd_q[n];
            pend_q[n] <= 1'b0;
            if (stop_q[n]) begin
              run_q[n]  <= 1'b0;
              stop_q[n] <= 1'b0;
            end
          end
          if (wr_upd[n]) begin
            shd_q[n]  <= bus_wdata[CW-1:0];
            pend_q[n] <= 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (glb_sel) begin
      case (bus_addr[4:0])
        5'h0C:   rd_mux[NCH-1:0] = run_q;
        5'h1C:   rd_mux[NCH-1:0] = isr_q;
        default: rd_mux = '0;
      endcase
    end else if (ch_sel) begin
      case (ch_reg)
        3'd0: begin
          rd_mux[POLB]   = pol_q[ch_idx];
          rd_mux[PW-1:0] = pre_q[ch_idx];
        end
        3'd1:    rd_mux[CW-1:0] = duty_q[ch_idx];
        3'd2:    rd_mux[CW-1:0] = shd_q[ch_idx];
        3'd3:    rd_mux[CW-1:0] = per_q[ch_idx];
        default: rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    // R1
    start_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q[g]) |-> $past(wr_ena && bus_wdata[g]));
    // R9
    stop_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q[g]) |-> $past(wrap[g]));
    // R8
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isr_q[g]) |-> $past(wrap[g]));
    // R6
    duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(run_q[g]) && run_q[g] && !$past(wrap[g])) |-> $stable(duty_q[g]));
    // R2
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q[g] && per_q[g] != '0) |-> (cnt_q[g] < per_q[g]));
  end
endmodule

// File: tb/tb_pwm_quad_ctrl.sv
module tb_pwm_quad_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  logic        irq;

  pwm_quad_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out), .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct { logic [3:0] v; string req; } item_t;
  item_t exp_q[$];

  int n_chk = 0, n_bad = 0, edge_n = 0, last_e = 0;
  bit done = 0;
  int st[4], stp[4], sw[4], per[4], d0[4], d1[4], sc[4], pl[4];

  always @(posedge clk) edge_n <= edge_n + 1;

  function automatic int exp_bit(int ch, int c);
    int k, cnt, d;
    if (c < st[ch] || c >= stp[ch]) return pl[ch];
    k = c - st[ch];
    cnt = (k >> sc[ch]) % per[ch];
    d = (c >= sw[ch]) ? d1[ch] : d0[ch];
    return ((cnt >= d) ? 1 : 0) ^ pl[ch];
  endfunction

  function automatic int next_wrap(int ch, int w);
    int len;
    len = per[ch] << sc[ch];
    return st[ch] + ((w - st[ch]) / len + 1) * len;
  endfunction

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      n_chk++;
      if (pwm_out !== it.v) begin
        n_bad++;
        $display("FAIL %s pwm_out actual=%b expected=%b edge=%0d", it.req, pwm_out, it.v, edge_n);
      end
    end
  end

  task automatic win(int n, string req);
    for (int i = 0; i < n; i++) begin
      item_t it;
      for (int ch = 0; ch < 4; ch++) it.v[ch] = exp_bit(ch, edge_n + i)[0];
      it.req = req;
      exp_q.push_back(it);
    end
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    last_e = edge_n;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, logic [31:0] e, string req);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    n_chk++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s read 0x%03h actual=0x%08h expected=0x%08h", req, a, bus_rdata, e);
    end
  endtask

  task automatic chk(logic got, logic e, string req);
    n_chk++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s irq actual=%b expected=%b", req, got, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int ch = 0; ch < 4; ch++) begin
      st[ch] = 1000000; stp[ch] = 1000000; sw[ch] = 1000000;
      per[ch] = 1; d0[ch] = 0; d1[ch] = 0; sc[ch] = 0; pl[ch] = 0;
    end
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R10 reset state
    rd(12'h00C, 0, "R10");
    rd(12'h01C, 0, "R10");
    rd(12'h20C, 0, "R10");
    win(2, "R10");
    chk(irq, 1'b0, "R10");

    // R5 field width and window layout
    wr(12'h20C, 32'hABCD_0008);
    rd(12'h20C, 32'h8, "R5");
    wr(12'h204, 32'hFFFF_0003);
    rd(12'h204, 32'h3, "R5");
    per[0] = 8; d0[0] = 3; d1[0] = 3;

    // R4 polarity and idle level, R3 prescale select
    wr(12'h220, 32'h0000_0202);
    rd(12'h220, 32'h202, "R4");
    wr(12'h22C, 5);
    wr(12'h224, 1);
    per[1] = 5; d0[1] = 1; d1[1] = 1; sc[1] = 2; pl[1] = 1;
    win(2, "R4");

    // R3 clamp of prescale above 10
    wr(12'h240, 32'h0000_000F);
    rd(12'h240, 32'hA, "R3");
    wr(12'h240, 0);

    // R11 unmapped offsets
    rd(12'h010, 0, "R11");
    rd(12'h214, 0, "R11");

    // R1 start two channels, R2 waveform
    wr(12'h004, 32'h3);
    st[0] = last_e; st[1] = last_e;
    win(48, "R2/R3/R4/R1");
    rd(12'h00C, 32'h3, "R1");

    // R6 direct writes refused while running, shadowed duty
    wr(12'h204, 7);
    wr(12'h20C, 9);
    rd(12'h204, 3, "R6");
    rd(12'h20C, 8, "R6");
    wr(12'h208, 6);
    d1[0] = 6; sw[0] = next_wrap(0, last_e);
    win(40, "R6");
    rd(12'h208, 6, "R6");
    rd(12'h204, 6, "R6");

    // R7 immediate writes on a stopped channel
    wr(12'h248, 4);
    rd(12'h244, 4, "R7");
    rd(12'h248, 4, "R7");
    wr(12'h24C, 12);
    rd(12'h24C, 12, "R7");

    // R9 delayed stop
    wr(12'h008, 32'h3);
    stp[0] = next_wrap(0, last_e);
    stp[1] = next_wrap(1, last_e);
    rd(12'h00C, 32'h3, "R9");
    win(50, "R9");
    rd(12'h00C, 0, "R9");

    // R8 flags and read-to-clear
    chk(irq, 1'b1, "R8");
    rd(12'h01C, 32'h3, "R8");
    rd(12'h01C, 0, "R8");
    chk(irq, 1'b0, "R8");

    // R1 all four running
    wr(12'h004, 32'hF);
    rd(12'h00C, 32'hF, "R1");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule